// File: doc/BRIEF.md
# Interrupt Flag Collector with Read-and-Clear

This block gathers up to eight single-cycle event pulses into sticky status flags. It qualifies them with an enable mask and drives an active-low interrupt request line, modelled as an open-drain pull-down. A host reads the flags through an abstracted serial port. The port reports three things to the block: a strobe when a command byte has finished, the address carried by that command, and one pulse for each data bit shifted back to the host.

Two kinds of read are supported. A plain status read returns the flags and leaves them in place. A read-and-clear returns the flags and clears exactly the ones it reported. Both reads freeze the returned byte at the end of the command byte. During a read-and-clear the request line is released from the end of the command byte until the eighth data bit has gone out. Any event that arrives in that window is kept, and it pulls the line low again once the window closes if its enable bit is set.

Flag 6 reports supply recovery. It comes up set after reset and can never raise the request, because its enable bit is always stored as zero. Flag 5 reports that a temperature conversion has finished.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flags read 40h (only the supply flag set), the enable mask is 00h, `irq_n` is 1, `irq_oe` is 0 and `rd_byte` is 00h.
- R2: An event pulse on input bit i sets flag i at the next clock edge, whatever enable bit i holds. The flag then stays set until a read-and-clear reports it.
- R3: Outside a read-and-clear window, `irq_n` is 0 in the same cycle (after the edge) that any flag is 1 while its enable bit is also 1. Otherwise `irq_n` is 1.
- R4: A write through `en_wr` loads the enable mask from `en_wdata`, except that bit 6 is always stored as 0. The supply flag (bit 6) therefore never pulls `irq_n` low.
- R5: A command that completes with address 04h latches the current flags (their value before that edge) into `rd_byte` and leaves the flags unchanged.
- R6: A command that completes with address 05h latches the current flags into `rd_byte` and clears those flags. An event that arrives in the command cycle or later stays pending.
- R7: After an accepted command with address 05h, `irq_n` is 1 from the next edge until the edge on which the eighth `bit_out` pulse is taken. After that edge it follows R3 using the pending flags.
- R8: A command that completes with any other address changes neither the flags, nor `rd_byte`, nor `irq_n`.
- R9: `irq_oe` is always the inverse of `irq_n`, so the line is pulled low only while an interrupt is requested.
- R10: `bit_out` pulses outside a read-and-clear window have no effect. A command strobe that arrives during the window is ignored and does not restart the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NUM_FLAGS | One-cycle event pulses, one per flag |
| en_wr | input | 1 | Enable mask write strobe |
| en_wdata | input | NUM_FLAGS | Enable mask write data |
| cmd_done | input | 1 | Command byte complete strobe |
| cmd_addr | input | ADDR_W | Address carried by the completed command |
| bit_out | input | 1 | One pulse per data bit shifted out |
| rd_byte | output | NUM_FLAGS | Status byte frozen at the last accepted status read |
| irq_n | output | 1 | Active-low interrupt request level |
| irq_oe | output | 1 | Pull-down enable for the open-drain request pin |

## Verification
Most faults inside the flag bank show up only through a status read. A flag that fails to set, or that is cleared when it should not be, appears as a wrong `rd_byte` after the next 04h command, or as a wrong `irq_n` in the cycle right after the event when the flag is enabled. A wrong bit counter in the read window shows as `irq_n` releasing one pulse too early or too late around the eighth `bit_out`. The bench steps through all 256 enable masks with a distinct event pattern for each, and places an event inside every read window, so a lost pending event is seen as a wrong `irq_n` and a wrong follow-up read within a few cycles.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int unsigned FLAG_W     = 8;
    localparam int unsigned XFER_BITS  = 8;
    localparam int unsigned CMD_ADDR_W = 6;

    localparam logic [CMD_ADDR_W-1:0] ADDR_PEEK  = 6'h04;
    localparam logic [CMD_ADDR_W-1:0] ADDR_CLEAR = 6'h05;

    localparam int unsigned SUPPLY_IDX = 6;
    localparam int unsigned TEMP_IDX   = 5;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_HOLD = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic take_snap;
        logic clear_snap;
    } rd_ctrl_t;

    function automatic rd_ctrl_t decode_cmd(
        input logic                  accept,
        input logic [CMD_ADDR_W-1:0] addr,
        input logic [CMD_ADDR_W-1:0] peek_addr,
        input logic [CMD_ADDR_W-1:0] clear_addr
    );
        rd_ctrl_t c;
        c.clear_snap = accept && (addr == clear_addr);
        c.take_snap  = accept && ((addr == clear_addr) || (addr == peek_addr));
        return c;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_FLAGS  = FLAG_W,
    parameter int unsigned FIXED_IDX  = SUPPLY_IDX
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_FLAGS-1:0] evt,
    input  rd_ctrl_t             ctrl,
    input  logic                 en_wr,
    input  logic [NUM_FLAGS-1:0] en_wdata,
    output logic [NUM_FLAGS-1:0] st_q,
    output logic [NUM_FLAGS-1:0] en_q,
    output logic [NUM_FLAGS-1:0] snap_q
);

    // One sticky flag and one enable bit per source; the fixed-off
    // source gets a constant-zero enable instead of a register.
    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
        localparam logic RST_VAL = (gi == FIXED_IDX);

        always_ff @(posedge clk) begin
            if (rst)
                st_q[gi] <= RST_VAL;
            else if (ctrl.clear_snap)
                st_q[gi] <= evt[gi];
            else
                st_q[gi] <= st_q[gi] | evt[gi];
        end

        if (gi == FIXED_IDX) begin : g_fixed_off
            assign en_q[gi] = 1'b0;
        end else begin : g_enable
            always_ff @(posedge clk) begin
                if (rst)
                    en_q[gi] <= 1'b0;
                else if (en_wr)
                    en_q[gi] <= en_wdata[gi];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= '0;
        else if (ctrl.take_snap)
            snap_q <= st_q;
    end

endmodule

// File: rtl/irq_rd_seq.sv
module irq_rd_seq
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned BYTE_BITS = XFER_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic bit_out,
    output logic hold
);

    localparam int unsigned CNT_W = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_BITS - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_HOLD;
                        cnt_q   <= '0;
                    end
                end
                SEQ_HOLD: begin
                    if (bit_out) begin
                        if (cnt_q == LAST_CNT) begin
                            state_q <= SEQ_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign hold = (state_q == SEQ_HOLD);

endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
    parameter int unsigned NUM_FLAGS = 8
) (
    input  logic [NUM_FLAGS-1:0] st,
    input  logic [NUM_FLAGS-1:0] en,
    input  logic                 hold,
    output logic                 irq_n,
    output logic                 irq_oe
);

    logic pull_low;

    always_comb begin
        pull_low = (|(st & en)) && !hold;
        irq_oe   = pull_low;
        irq_n    = !pull_low;
    end

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_FLAGS  = FLAG_W,
    parameter int unsigned ADDR_W     = CMD_ADDR_W,
    parameter int unsigned BYTE_BITS  = XFER_BITS,
    parameter int unsigned FIXED_IDX  = SUPPLY_IDX,
    parameter logic [ADDR_W-1:0] PEEK_ADDR  = ADDR_W'(ADDR_PEEK),
    parameter logic [ADDR_W-1:0] CLEAR_ADDR = ADDR_W'(ADDR_CLEAR)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_FLAGS-1:0] evt_pulse,
    input  logic                 en_wr,
    input  logic [NUM_FLAGS-1:0] en_wdata,
    input  logic                 cmd_done,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic                 bit_out,
    output logic [NUM_FLAGS-1:0] rd_byte,
    output logic                 irq_n,
    output logic                 irq_oe
);

    logic                 rd_hold;
    logic                 cmd_accept;
    rd_ctrl_t             rd_ctrl;
    logic [NUM_FLAGS-1:0] st_q;
    logic [NUM_FLAGS-1:0] en_q;

    assign cmd_accept = cmd_done && !rd_hold;

    always_comb begin
        rd_ctrl.clear_snap = cmd_accept && (cmd_addr == CLEAR_ADDR);
        rd_ctrl.take_snap  = cmd_accept &&
                             ((cmd_addr == CLEAR_ADDR) || (cmd_addr == PEEK_ADDR));
    end

    irq_flag_bank #(
        .NUM_FLAGS (NUM_FLAGS),
        .FIXED_IDX (FIXED_IDX)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_pulse),
        .ctrl     (rd_ctrl),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .st_q     (st_q),
        .en_q     (en_q),
        .snap_q   (rd_byte)
    );

    irq_rd_seq #(
        .BYTE_BITS (BYTE_BITS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (rd_ctrl.clear_snap),
        .bit_out (bit_out),
        .hold    (rd_hold)
    );

    irq_pin_drv #(
        .NUM_FLAGS (NUM_FLAGS)
    ) u_pin (
        .st     (st_q),
        .en     (en_q),
        .hold   (rd_hold),
        .irq_n  (irq_n),
        .irq_oe (irq_oe)
    );

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
    parameter int unsigned NUM_FLAGS = 8,
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned FIXED_IDX = 6,
    parameter logic [ADDR_W-1:0] PEEK_ADDR  = 6'h04,
    parameter logic [ADDR_W-1:0] CLEAR_ADDR = 6'h05
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_FLAGS-1:0] evt_pulse,
    input logic                 cmd_done,
    input logic [ADDR_W-1:0]    cmd_addr,
    input logic                 irq_n,
    input logic [NUM_FLAGS-1:0] st_q,
    input logic [NUM_FLAGS-1:0] en_q,
    input logic                 rd_hold
);

    localparam logic [NUM_FLAGS-1:0] FIXED_MASK = NUM_FLAGS'(1) << FIXED_IDX;

    // R2: every pulsed source shows as set in the following cycle
    a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
        (|evt_pulse) |=> ((st_q & $past(evt_pulse)) == $past(evt_pulse)));

    // R3: a live enabled flag outside the read window pulls the line low
    a_r3_irq_asserts: assert property (@(posedge clk) disable iff (rst)
        (!rd_hold && ((st_q & en_q) != '0)) |-> !irq_n);

    // R4: the line is never pulled low by the fixed-off supply flag alone
    a_r4_supply_silent: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> ((st_q & en_q & ~FIXED_MASK) != '0));

    // R5: a plain read leaves every flag it saw in place
    a_r5_peek_keeps: assert property (@(posedge clk) disable iff (rst)
        (cmd_done && !rd_hold && cmd_addr == PEEK_ADDR)
        |=> ((st_q & $past(st_q)) == $past(st_q)));

    // R6: read-and-clear drops reported flags unless they fired again
    a_r6_clear_reported: assert property (@(posedge clk) disable iff (rst)
        (cmd_done && !rd_hold && cmd_addr == CLEAR_ADDR)
        |=> ((st_q & $past(st_q) & ~$past(evt_pulse)) == '0));

    // R7: the line is released right after an accepted read-and-clear
    a_r7_release_window: assert property (@(posedge clk) disable iff (rst)
        (cmd_done && !rd_hold && cmd_addr == CLEAR_ADDR) |=> irq_n);

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
    .NUM_FLAGS  (NUM_FLAGS),
    .ADDR_W     (ADDR_W),
    .FIXED_IDX  (FIXED_IDX),
    .PEEK_ADDR  (PEEK_ADDR),
    .CLEAR_ADDR (CLEAR_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_pulse (evt_pulse),
    .cmd_done  (cmd_done),
    .cmd_addr  (cmd_addr),
    .irq_n     (irq_n),
    .st_q      (st_q),
    .en_q      (en_q),
    .rd_hold   (rd_hold)
);

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;

    localparam logic [5:0] A_PEEK  = 6'h04;
    localparam logic [5:0] A_CLEAR = 6'h05;
    localparam logic [5:0] A_OTHER = 6'h0E;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] evt_pulse = '0;
    logic       en_wr = 1'b0;
    logic [7:0] en_wdata = '0;
    logic       cmd_done = 1'b0;
    logic [5:0] cmd_addr = '0;
    logic       bit_out = 1'b0;
    logic [7:0] rd_byte;
    logic       irq_n;
    logic       irq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the block state
    logic [7:0] m_st   = 8'h40;
    logic [7:0] m_en   = 8'h00;
    logic [7:0] m_snap = 8'h00;
    bit         m_hold = 1'b0;
    int         m_cnt  = 0;

    always #2 clk = ~clk;

    irq_flag_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .evt_pulse (evt_pulse),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .cmd_done  (cmd_done),
        .cmd_addr  (cmd_addr),
        .bit_out   (bit_out),
        .rd_byte   (rd_byte),
        .irq_n     (irq_n),
        .irq_oe    (irq_oe)
    );

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        logic exp_n;
        exp_n = m_hold ? 1'b1 : ((m_st & m_en) == 8'h00);
        chk(tag, "irq_n", {7'd0, irq_n}, {7'd0, exp_n});
        chk("R9", "irq_oe", {7'd0, irq_oe}, {7'd0, ~exp_n});
        chk(tag, "rd_byte", rd_byte, m_snap);
    endtask

    task automatic step(input logic [7:0] ev, input logic cd, input logic [5:0] ad,
                        input logic bo, input logic ew, input logic [7:0] wd,
                        input string tag);
        bit acc;
        @(negedge clk);
        evt_pulse = ev; cmd_done = cd; cmd_addr = ad;
        bit_out = bo; en_wr = ew; en_wdata = wd;
        @(posedge clk);
        acc = cd && !m_hold;
        if (m_hold && bo) begin
            m_cnt++;
            if (m_cnt == 8) begin
                m_hold = 1'b0;
                m_cnt  = 0;
            end
        end
        if (acc && ad == A_CLEAR) begin
            m_snap = m_st;
            m_st   = ev;
            m_hold = 1'b1;
            m_cnt  = 0;
        end else if (acc && ad == A_PEEK) begin
            m_snap = m_st;
            m_st   = m_st | ev;
        end else begin
            m_st = m_st | ev;
        end
        if (ew) m_en = wd & 8'hBF;
        #1;
        check_outs(tag);
    endtask

    task automatic idle(input string tag);
        step(8'h00, 1'b0, 6'h00, 1'b0, 1'b0, 8'h00, tag);
    endtask

    // plain read, then compare the returned byte with the expected flags
    task automatic peek(input string tag);
        logic [7:0] exp_flags;
        exp_flags = m_st;
        step(8'h00, 1'b1, A_PEEK, 1'b0, 1'b0, 8'h00, tag);
        chk(tag, "status via peek", rd_byte, exp_flags);
    endtask

    // read-and-clear, optional event injected at data bit position inj_at
    task automatic clear_read(input logic [7:0] inj, input int inj_at, input string tag);
        step(8'h00, 1'b1, A_CLEAR, 1'b0, 1'b0, 8'h00, tag);
        for (int b = 0; b < 8; b++) begin
            step((b == inj_at) ? inj : 8'h00, 1'b0, 6'h00, 1'b1, 1'b0, 8'h00, tag);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] p, q;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1: reset state at the pins, then the flags through a plain read
        check_outs("R1");
        peek("R1");

        // R4: writing all ones keeps bit 6 off, supply flag stays silent
        step(8'h00, 1'b0, 6'h00, 1'b0, 1'b1, 8'hFF, "R4");
        chk("R4", "irq_n with only supply flag", {7'd0, irq_n}, 8'h01);
        step(8'h40, 1'b0, 6'h00, 1'b0, 1'b0, 8'h00, "R4");
        chk("R4", "irq_n after supply event", {7'd0, irq_n}, 8'h01);

        // R6: clear the power-up flag, R10: extra bit pulses are ignored
        clear_read(8'h00, -1, "R6");
        chk("R6", "snapshot of power-up flags", rd_byte, 8'h40);
        step(8'h00, 1'b0, 6'h00, 1'b1, 1'b0, 8'h00, "R10");
        step(8'h00, 1'b0, 6'h00, 1'b1, 1'b0, 8'h00, "R10");
        peek("R6");

        // R2: flags stick with enable cleared, line stays released
        step(8'h00, 1'b0, 6'h00, 1'b0, 1'b1, 8'h00, "R2");
        step(8'h21, 1'b0, 6'h00, 1'b0, 1'b0, 8'h00, "R2");
        idle("R2");
        idle("R2");
        peek("R2");
        chk("R2", "irq_n with enables off", {7'd0, irq_n}, 8'h01);

        // R8: unrelated address leaves flags, rd_byte and irq unchanged
        step(8'h00, 1'b1, A_OTHER, 1'b0, 1'b0, 8'h00, "R8");
        chk("R8", "rd_byte after other address", rd_byte, 8'h21);
        peek("R8");

        // R5: plain read keeps flags, R3: enabling raises the request
        step(8'h00, 1'b0, 6'h00, 1'b0, 1'b1, 8'h20, "R3");
        chk("R3", "irq_n after enable write", {7'd0, irq_n}, 8'h00);
        peek("R5");
        peek("R5");

        // R6: event in the command cycle goes to pending, not the snapshot
        step(8'h02, 1'b1, A_CLEAR, 1'b0, 1'b0, 8'h00, "R6");
        chk("R6", "snapshot excludes same-cycle event", rd_byte, 8'h21);
        // R10: command during the window is ignored, count not restarted
        step(8'h00, 1'b0, 6'h00, 1'b1, 1'b0, 8'h00, "R7");
        step(8'h00, 1'b1, A_CLEAR, 1'b1, 1'b0, 8'h00, "R10");
        step(8'h00, 1'b1, A_PEEK, 1'b0, 1'b0, 8'h00, "R10");
        chk("R10", "rd_byte unchanged by ignored command", rd_byte, 8'h21);
        for (int b = 2; b < 8; b++) begin
            step(8'h00, 1'b0, 6'h00, 1'b1, 1'b0, 8'h00, "R7");
        end
        peek("R6");
        clear_read(8'h00, -1, "R6");

        // sweep every enable mask with its own event pattern
        for (int e = 0; e < 256; e++) begin
            p = 8'((e * 37 + 11) & 8'hFF);
            q = {p[0], p[7:1]} ^ 8'h5A;
            step(8'h00, 1'b0, 6'h00, 1'b0, 1'b1, 8'(e), "R4");
            step(p, 1'b0, 6'h00, 1'b0, 1'b0, 8'h00, "R3");
            peek("R2");
            // R7: line held released while bits shift, then follows pending q
            clear_read(q, e % 8, "R7");
            chk("R6", "snapshot equals swept pattern", rd_byte, p);
            peek("R6");
            clear_read(8'h00, -1, "R6");
        end

        idle("R3");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule